// File: doc/BRIEF.md
# Multi-Core Inter-Processor Interrupt Controller

This block holds one bank of interrupt registers for each core of a multi-core cluster. All banks sit behind one 32-bit register port. The requester identity that comes with each access selects the bank. Each bank has the following parts:

- an enable word;
- a pending-status word that can only be read;
- a write-only set port and a write-only clear port that change the status;
- eight 32-bit mailbox words;
- one interrupt output line.

A core signals another core by writing a send command. The command carries a target core number and a bit number. It sets that status bit on the target core exactly as a set-port write would.

The interrupt line follows edge-conditioned rules, not a continuous status-and-enable product. The line rises only on a set operation that leaves some enabled status bit pending. It falls only on a clear operation that empties the status while the enable is non-zero. A write to the enable word leaves the line unchanged. A send command whose target has no core is refused: it raises a one-cycle error pulse and changes no state.

The window of each bank is 0x48 bytes. Word offsets are as follows:

| Byte offset | Register |
|---|---|
| 0x00 | enable |
| 0x04 | status |
| 0x08 | set |
| 0x0C | clear |
| 0x10 | send command |
| 0x20 to 0x3C | mailbox |

Top module: `ipi_ctrl`

## Requirements
- R1: The enable word at offset 0x00 is read and written as 32 bits. With the default registered read, `rd_data` shows the addressed word in the cycle after the clock edge that samples `rd_en`.
- R2: The status word at 0x04 can only be read. A write to 0x04 leaves it unchanged.
- R3: A write to the set port at 0x08 ORs the data into status. If the new status is non-zero and has a bit in common with enable, `irq[core]` is 1 after that edge. Otherwise the line keeps its value. Reads of 0x08 and 0x0C return 0.
- R4: A write to the clear port at 0x0C removes the written bits from status. `irq[core]` goes to 0 only if the resulting status is zero and enable is non-zero. Otherwise the line keeps its value, including when enable is zero.
- R5: Each core has 8 mailbox words at 0x20 to 0x3C. The word index is (offset - 0x20) >> 2. Words are independent per core and per index.
- R6: A write to the send command at 0x10 takes the target core from bits 25:16 and the bit number from bits 4:0. It acts on the target core as a set-port write of the single bit (1 << bit number). The requester's own bank is unaffected.
- R7: A send command whose target is NCORES or more drives `err` high for exactly the cycle after the write. It changes no status and no interrupt line. `err` is 0 at all other times.
- R8: `req_id` selects the bank. A write never changes another core's bank. With `req_id` of NCORES or more, reads return 0 and writes have no effect.
- R9: Reads of an unmapped offset, or of an offset with bits 1:0 not zero, return 0. Writes to such offsets have no effect.
- R10: While `rst_n` is low at a clock edge, status, enable and every mailbox word are cleared, all `irq` lines go to 0, and `err` goes to 0.
- R11: A write to the enable word does not change `irq`. A status bit that is pending when it becomes enabled raises the line only at the next set operation on that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_id | input | REQ_ID_W | Identity of the requesting core; selects the register bank |
| addr | input | ADDR_W | Byte offset within the bank window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data (one cycle after `rd_en` when RD_REG=1) |
| err | output | 1 | One-cycle pulse: a send command named a core that does not exist |
| irq | output | NCORES | One interrupt line per core |

## Verification
Set and clear writes are applied in several orders, each chosen to separate the edge-conditioned rules from a plain status-and-enable product:
- a pending bit is set while disabled and then enabled;
- a partial clear leaves a bit pending;
- a full clear is made while enable is zero.

Send commands are issued to a valid target and to a missing one. The first shows that only the target's bank moves. The second shows that the refusal leaves all state unchanged and pulses `err`.

Mailbox words are written at both ends of the range on two cores, which exposes index and bank mix-ups. Accesses with an out-of-range requester, an unmapped offset and a misaligned offset are each followed by reads that show nothing changed.

// File: rtl/ipi_ctrl_pkg.sv
package ipi_ctrl_pkg;
   localparam int WORD_W = 32;

   // Word offsets (byte offset >> 2) inside the bank window
   localparam int WOFF_EN   = 0;
   localparam int WOFF_STAT = 1;
   localparam int WOFF_SET  = 2;
   localparam int WOFF_CLR  = 3;
   localparam int WOFF_SEND = 4;
   localparam int WOFF_MBX  = 8;
   localparam int WINDOW_BYTES = 'h48;

   // Send command fields
   localparam int SEND_TGT_LSB = 16;
   localparam int SEND_TGT_W   = 10;
   localparam int SEND_VEC_W   = 5;

   typedef enum logic [2:0] {
      OP_NONE, OP_EN, OP_STAT, OP_SET, OP_CLR, OP_SEND, OP_MBX
   } ipi_op_e;

   function automatic logic [WORD_W-1:0] vec_to_bit(input logic [SEND_VEC_W-1:0] v);
      return WORD_W'(1) << v;
   endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
   import ipi_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int MBX_WORDS = 8,
   localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1,
   localparam int WORD_AW   = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output ipi_op_e              op,
   output logic [MBX_IDX_W-1:0] mbx_idx
);
   logic [WORD_AW-1:0] word;
   logic               aligned;
   int                 w;

   assign word    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign w       = int'(word);
   assign mbx_idx = MBX_IDX_W'(word - WORD_AW'(WOFF_MBX));

   always_comb begin
      op = OP_NONE;
      if (aligned) begin
         if (w == WOFF_EN)        op = OP_EN;
         else if (w == WOFF_STAT) op = OP_STAT;
         else if (w == WOFF_SET)  op = OP_SET;
         else if (w == WOFF_CLR)  op = OP_CLR;
         else if (w == WOFF_SEND) op = OP_SEND;
         else if (w >= WOFF_MBX && w < WOFF_MBX + MBX_WORDS) op = OP_MBX;
      end
   end
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
   import ipi_ctrl_pkg::*;
#(
   parameter int MBX_WORDS = 8,
   localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 own_wr,
   input  ipi_op_e                              op,
   input  logic [MBX_IDX_W-1:0]                 mbx_idx,
   input  logic [WORD_W-1:0]                    wdata,
   input  logic                                 send_hit,
   input  logic [SEND_VEC_W-1:0]                send_vec,
   output logic [WORD_W-1:0]                    status_o,
   output logic [WORD_W-1:0]                    enable_o,
   output logic [MBX_WORDS-1:0][WORD_W-1:0]     mbx_o,
   output logic                                 irq_o
);
   logic              set_go, clr_go;
   logic [WORD_W-1:0] set_val, stat_nxt;

   assign set_go  = (own_wr && op == OP_SET) || send_hit;
   assign clr_go  = own_wr && op == OP_CLR;
   assign set_val = send_hit ? vec_to_bit(send_vec) : wdata;

   always_comb begin
      stat_nxt = status_o;
      if (set_go)      stat_nxt = status_o | set_val;
      else if (clr_go) stat_nxt = status_o & ~wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_o <= '0;
         enable_o <= '0;
         irq_o    <= 1'b0;
      end else begin
         status_o <= stat_nxt;
         if (own_wr && op == OP_EN) enable_o <= wdata;
         if (set_go && stat_nxt != '0 && (stat_nxt & enable_o) != '0)
            irq_o <= 1'b1;
         else if (clr_go && stat_nxt == '0 && enable_o != '0)
            irq_o <= 1'b0;
      end
   end

   for (genvar k = 0; k < MBX_WORDS; k++) begin : g_mbx
      always_ff @(posedge clk) begin
         if (!rst_n)
            mbx_o[k] <= '0;
         else if (own_wr && op == OP_MBX && mbx_idx == MBX_IDX_W'(k))
            mbx_o[k] <= wdata;
      end
   end

   // R3: the line only rises on a set operation
   assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(irq_o)) |-> $past(set_go));
   // R3: a set that leaves an enabled bit pending raises the line
   assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_go && (stat_nxt & enable_o) != '0) |=> irq_o);
   // R4: the line only falls on a clear that empties status
   assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(irq_o)) |-> ($past(clr_go) && status_o == '0));
   // R2: status moves only through set, clear or send
   assert_status_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(status_o)) |-> $past(set_go || clr_go));
   // R11: an enable write alone keeps the line
   assert_enable_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr && op == OP_EN && !send_hit) |=> $stable(irq_o));
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
   import ipi_ctrl_pkg::*;
#(
   parameter int NCORES    = 4,
   parameter int REQ_ID_W  = 3,
   parameter int ADDR_W    = 7,
   parameter int MBX_WORDS = 8,
   parameter bit RD_REG    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REQ_ID_W-1:0] req_id,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic [31:0]         wr_data,
   input  logic                rd_en,
   output logic [31:0]         rd_data,
   output logic                err,
   output logic [NCORES-1:0]   irq
);
   localparam int MBX_IDX_W = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1;

   if (NCORES < 1 || NCORES > (1 << SEND_TGT_W)) begin : g_bad_ncores
      $error("NCORES must be between 1 and 1024");
   end
   if ((1 << REQ_ID_W) < NCORES) begin : g_bad_reqw
      $error("REQ_ID_W too narrow for NCORES");
   end
   if (MBX_WORDS < 1 || 4 * (WOFF_MBX + MBX_WORDS) > WINDOW_BYTES) begin : g_bad_mbx
      $error("MBX_WORDS does not fit the window");
   end
   if ((1 << ADDR_W) < WINDOW_BYTES) begin : g_bad_addr
      $error("ADDR_W too narrow for the window");
   end

   ipi_op_e                                       op;
   logic [MBX_IDX_W-1:0]                          mbx_idx;
   logic                                          req_ok, send_go, send_bad;
   logic [SEND_TGT_W-1:0]                         tgt;
   logic [NCORES-1:0][WORD_W-1:0]                 stat_a, en_a;
   logic [NCORES-1:0][MBX_WORDS-1:0][WORD_W-1:0]  mbx_a;
   logic [WORD_W-1:0]                             rd_word;

   ipi_addr_decode #(.ADDR_W(ADDR_W), .MBX_WORDS(MBX_WORDS)) u_dec (
      .addr(addr), .op(op), .mbx_idx(mbx_idx));

   assign req_ok   = int'(req_id) < NCORES;
   assign tgt      = wr_data[SEND_TGT_LSB +: SEND_TGT_W];
   assign send_go  = wr_en && req_ok && op == OP_SEND;
   assign send_bad = send_go && int'(tgt) >= NCORES;

   for (genvar i = 0; i < NCORES; i++) begin : g_core
      ipi_core_bank #(.MBX_WORDS(MBX_WORDS)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .own_wr   (wr_en && req_ok && req_id == REQ_ID_W'(i)),
         .op       (op),
         .mbx_idx  (mbx_idx),
         .wdata    (wr_data),
         .send_hit (send_go && int'(tgt) == i),
         .send_vec (wr_data[SEND_VEC_W-1:0]),
         .status_o (stat_a[i]),
         .enable_o (en_a[i]),
         .mbx_o    (mbx_a[i]),
         .irq_o    (irq[i])
      );
   end

   always_comb begin
      rd_word = '0;
      if (req_ok) begin
         for (int i = 0; i < NCORES; i++) begin
            if (req_id == REQ_ID_W'(i)) begin
               case (op)
                  OP_EN:   rd_word = en_a[i];
                  OP_STAT: rd_word = stat_a[i];
                  OP_MBX:  rd_word = mbx_a[i][mbx_idx];
                  default: rd_word = '0;
               endcase
            end
         end
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n)     rd_data <= '0;
         else if (rd_en) rd_data <= rd_word;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= send_bad;
   end

   // R7: err pulses only after a send to a missing core
   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && err) |-> $past(send_bad));
   // R7: a refused send leaves every status word unchanged
   assert_bad_send_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      send_bad |=> ($stable(stat_a) && $stable(irq)));
   // R8: an out-of-range requester changes no state
   assert_bad_req_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !req_ok) |=> ($stable(stat_a) && $stable(en_a) && $stable(mbx_a)));
   // R10: reset drops every line
   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (irq == '0 && err == 1'b0));
endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req_id = '0;
   logic [6:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        err;
   logic [NC-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   ipi_ctrl u_ipi_ctrl (
      .clk(clk), .rst_n(rst_n), .req_id(req_id), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .err(err), .irq(irq));

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input int core, input int a, input logic [31:0] d);
      @(negedge clk);
      req_id = 3'(core); addr = 7'(a); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected word; monitor compares it
   task automatic rd(input int core, input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_id = 3'(core); addr = 7'(a); rd_en = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL monitor: read result with no expected item (got %h, expected none)", rd_data);
         end else begin
            chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end (got timeout, expected completion)");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(32'(irq), 32'h0, "R10 irq after reset");
      chk(32'(err), 32'h0, "R10 err after reset");
      rd(0, 'h04, 32'h0, "R10 status after reset");
      rd(0, 'h20, 32'h0, "R10 mailbox after reset");

      wr(0, 'h00, 32'h0000_00F0);
      rd(0, 'h00, 32'h0000_00F0, "R1 enable readback");
      wr(0, 'h04, 32'h0000_FFFF);
      rd(0, 'h04, 32'h0, "R2 status ignores writes");

      wr(0, 'h08, 32'h1);
      chk(32'(irq[0]), 32'h0, "R3 set of disabled bit keeps irq low");
      rd(0, 'h04, 32'h1, "R3 status after set");
      wr(0, 'h00, 32'h0000_00F1);
      chk(32'(irq[0]), 32'h0, "R11 enable write does not raise irq");
      wr(0, 'h08, 32'h0);
      chk(32'(irq[0]), 32'h1, "R11 next set raises irq");
      rd(0, 'h08, 32'h0, "R3 set port reads zero");
      rd(0, 'h0C, 32'h0, "R3 clear port reads zero");
      wr(0, 'h08, 32'h10);
      wr(0, 'h0C, 32'h1);
      chk(32'(irq[0]), 32'h1, "R4 partial clear keeps irq");
      rd(0, 'h04, 32'h10, "R4 status after partial clear");
      wr(0, 'h0C, 32'h10);
      chk(32'(irq[0]), 32'h0, "R4 full clear drops irq");

      wr(2, 'h00, 32'h1);
      wr(2, 'h08, 32'h1);
      chk(32'(irq[2]), 32'h1, "R3 core2 raise");
      wr(2, 'h00, 32'h0);
      wr(2, 'h0C, 32'h1);
      chk(32'(irq[2]), 32'h1, "R4 clear with enable zero keeps irq");
      rd(2, 'h04, 32'h0, "R4 core2 status cleared");

      wr(1, 'h20, 32'hA1A1_0001);
      wr(1, 'h3C, 32'hB1B1_0007);
      wr(2, 'h20, 32'hC2C2_0000);
      rd(1, 'h20, 32'hA1A1_0001, "R5 core1 word0");
      rd(1, 'h3C, 32'hB1B1_0007, "R5 core1 word7");
      rd(2, 'h20, 32'hC2C2_0000, "R8 core2 word0 separate");
      rd(1, 'h24, 32'h0, "R5 core1 word1 untouched");

      wr(3, 'h00, 32'h20);
      wr(0, 'h10, 32'h0003_0005);
      chk(32'(irq[3]), 32'h1, "R6 send raises target irq");
      chk(32'(irq[0]), 32'h0, "R6 sender irq unchanged");
      chk(32'(err), 32'h0, "R7 valid send gives no err");
      rd(3, 'h04, 32'h20, "R6 target status bit 5");
      rd(0, 'h04, 32'h0, "R6 sender status unchanged");

      wr(1, 'h10, 32'h0009_0001);
      chk(32'(err), 32'h1, "R7 err after send to missing core");
      @(negedge clk);
      chk(32'(err), 32'h0, "R7 err is one cycle");
      chk(32'(irq), 32'hC, "R7 irq lines unchanged");
      rd(3, 'h04, 32'h20, "R7 core3 status unchanged");
      rd(1, 'h04, 32'h0, "R7 core1 status unchanged");

      wr(5, 'h00, 32'hFF);
      rd(5, 'h00, 32'h0, "R8 out-of-range requester reads zero");
      rd(1, 'h00, 32'h0, "R8 out-of-range write changed nothing");

      rd(0, 'h14, 32'h0, "R9 unmapped read zero");
      wr(1, 'h44, 32'hFFFF_FFFF);
      rd(1, 'h3C, 32'hB1B1_0007, "R9 unmapped write no effect");
      wr(0, 'h01, 32'h0);
      rd(0, 'h00, 32'h0000_00F1, "R9 misaligned write no effect");
      rd(0, 'h05, 32'h0, "R9 misaligned read zero");

      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(32'(irq), 32'h0, "R10 reset drops irq");
      rd(1, 'h20, 32'h0, "R10 reset clears mailbox");
      rd(3, 'h04, 32'h0, "R10 reset clears status");
      rd(0, 'h00, 32'h0, "R10 reset clears enable");

      @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: %0d reads pending (expected 0)", exp_q.size());
      end
      done = 1;
      summary();
   end
endmodule